// File: doc/BRIEF.md
# Sequential Integer Divider with Modelled Completion Latency

This block divides a 32-bit dividend by a 32-bit divisor, either as unsigned numbers or as two's-complement numbers. It returns the truncated quotient. In the surrounding core the divisor always comes from one fixed general register, and the quotient is written back over the register that held the dividend. The block only sees the two operand values, a mode bit and a start strobe. It gives back the quotient, a one-cycle done pulse and a busy level.

Besides the arithmetic, the block models how long the operation takes. It counts the leading zeros of both operands and turns the difference into an execution-cycle figure. That figure is corrected for the sign in signed mode and then reduced by the overlap with the memory cycle time. The resulting extra-stall count is reported, and the block stays busy at least that long before raising done. A zero divisor never starts a division. It raises a divide-by-zero trap carrying trap number 7.

Top module: `div_seq_unit`

## Requirements
- R1: After reset, busy, done, dz_trap, quotient, lat_cycles and trap_code are all zero.
- R2: In unsigned mode (is_signed = 0) the quotient is floor(dividend / divisor) of the two operands read as unsigned numbers. It appears on quotient in the same cycle that done is high, and it holds until the next done.
- R3: In signed mode (is_signed = 1) the operands are two's complement and the quotient is truncated toward zero. It is negative when exactly one operand is negative. The case 0x80000000 / -1 wraps to 0x80000000.
- R4: In unsigned mode lat_cycles = max(E - 2*MEM_CYCLES + 1, 0), with E = 5 + lz(divisor) - lz(dividend). lz counts leading zeros from bit 31 down and gives 32 for a zero value.
- R5: In signed mode E = 6 + lz(|divisor|) - lz(|dividend|) + s, where s = 1 when exactly one operand is negative (zero counts as non-negative) and 0 otherwise. lat_cycles follows the same formula as R4.
- R6: When E < 2*MEM_CYCLES - 1, including negative E, lat_cycles is 0.
- R7: A start accepted at edge k gives done high for exactly one cycle, after edge k + N + 1. N = max(I, lat_cycles), and I = lz(|divisor|) - lz(|dividend|) + 1 when that difference is not negative, otherwise 0.
- R8: A start with divisor zero while idle gives dz_trap = 1 and trap_code = 7 for the one cycle after that edge. It gives no done, leaves busy low, and leaves quotient and lat_cycles unchanged.
- R9: A start while busy is ignored. The running operation finishes on its original schedule with its own quotient, and lat_cycles stays stable while busy.
- R10: busy rises on the edge that accepts a start and falls on the edge that raises done. A start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division (taken only when idle) |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend value |
| divisor | input | 32 | Divisor value (from the fixed divisor register) |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse, quotient valid |
| quotient | output | 32 | Truncated quotient of the last finished division |
| lat_cycles | output | 7 | Modelled extra stall cycles of the last accepted division |
| dz_trap | output | 1 | One-cycle divide-by-zero trap pulse |
| trap_code | output | 3 | Trap number, 7 during dz_trap, else 0 |

## Verification
After the edge that accepts a start, busy and lat_cycles change at once. The trap pulse also follows that same edge, while done and the new quotient come N + 1 edges later. N is the larger of the modelled stall and the number of quotient bits still to resolve. The reference model in the bench works out that due edge from the operands alone, using leading-zero counts, division operators and integer arithmetic. It then compares every output one time unit after every rising edge. This catches both a late done and an early done, as well as any start that is wrongly accepted or wrongly dropped.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

    // Trap number raised for an integer divide by zero
    localparam logic [2:0] TRAP_DIV0 = 3'd7;

endpackage

// File: rtl/div_lzc.sv
// Leading-zero counter: scans from the top bit down, saturates at W
module div_lzc #(
    parameter int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  value,
    output logic [CW-1:0] zeros
);
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (value[i]) zeros = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/div_lat_model.sv
// Operand conditioning and latency model for one division request
module div_lat_model #(
    parameter int W          = 32,
    parameter int MEM_CYCLES = 1,
    parameter int BASE_U     = 5,
    parameter int BASE_S     = 6,
    parameter int LAT_W      = 7,
    localparam int CW        = $clog2(W + 1)
) (
    input  logic             is_signed,
    input  logic [W-1:0]     dividend,
    input  logic [W-1:0]     divisor,
    output logic [W-1:0]     mag_n,
    output logic [W-1:0]     mag_d,
    output logic             neg_q,
    output logic [CW-1:0]    shift_k,
    output logic [LAT_W-1:0] iters,
    output logic [LAT_W-1:0] stall
);
    localparam int THRESH = 2 * MEM_CYCLES - 1;
    localparam logic [W-1:0] ONE_W = W'(1);

    logic          neg_n;
    logic          neg_d;
    logic [CW-1:0] lz_n;
    logic [CW-1:0] lz_d;
    int            exe;

    assign neg_n = is_signed & dividend[W-1];
    assign neg_d = is_signed & divisor[W-1];
    assign mag_n = neg_n ? (~dividend + ONE_W) : dividend;
    assign mag_d = neg_d ? (~divisor + ONE_W) : divisor;
    assign neg_q = neg_n ^ neg_d;

    div_lzc #(.W(W)) u_lz_n (.value(mag_n), .zeros(lz_n));
    div_lzc #(.W(W)) u_lz_d (.value(mag_d), .zeros(lz_d));

    always_comb begin
        exe = (is_signed ? BASE_S : BASE_U) + int'(lz_d) - int'(lz_n)
            + (neg_q ? 1 : 0);
        if (exe >= THRESH) stall = LAT_W'(exe - THRESH);
        else               stall = '0;
        if (lz_d >= lz_n) begin
            shift_k = lz_d - lz_n;
            iters   = LAT_W'(int'(lz_d) - int'(lz_n) + 1);
        end else begin
            shift_k = '0;
            iters   = '0;
        end
    end
endmodule

// File: rtl/div_seq_unit.sv
// Sequential signed/unsigned divider with modelled completion latency
module div_seq_unit #(
    parameter int WIDTH      = 32,
    parameter int MEM_CYCLES = 1,
    parameter int BASE_U     = 5,
    parameter int BASE_S     = 6,
    localparam int LAT_W     = $clog2(2 * WIDTH + BASE_S + 2),
    localparam int CW        = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [LAT_W-1:0] lat_cycles,
    output logic             dz_trap,
    output logic [2:0]       trap_code
);
    import div_pkg::*;

    localparam logic [LAT_W-1:0] ONE_L = LAT_W'(1);
    localparam logic [WIDTH-1:0] ONE_W = WIDTH'(1);

    typedef struct packed {
        div_state_e       state;
        logic [LAT_W-1:0] cnt;
        logic [LAT_W-1:0] steps;
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] dsh;
        logic [WIDTH-1:0] qacc;
        logic             neg;
        logic             done;
        logic             trap;
        logic [2:0]       tcode;
        logic [WIDTH-1:0] quot;
        logic [LAT_W-1:0] lat;
    } regs_t;

    regs_t r_d;
    regs_t r_q;

    logic [WIDTH-1:0] mag_n;
    logic [WIDTH-1:0] mag_d;
    logic             neg_q;
    logic [CW-1:0]    shift_k;
    logic [LAT_W-1:0] iters;
    logic [LAT_W-1:0] stall;

    div_lat_model #(
        .W(WIDTH), .MEM_CYCLES(MEM_CYCLES),
        .BASE_U(BASE_U), .BASE_S(BASE_S), .LAT_W(LAT_W)
    ) u_model (
        .is_signed(is_signed),
        .dividend (dividend),
        .divisor  (divisor),
        .mag_n    (mag_n),
        .mag_d    (mag_d),
        .neg_q    (neg_q),
        .shift_k  (shift_k),
        .iters    (iters),
        .stall    (stall)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.trap  = 1'b0;
        r_d.tcode = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (divisor == '0) begin
                        r_d.trap  = 1'b1;
                        r_d.tcode = TRAP_DIV0;
                    end else begin
                        r_d.state = ST_RUN;
                        r_d.cnt   = (iters > stall) ? iters : stall;
                        r_d.steps = iters;
                        r_d.rem   = mag_n;
                        r_d.dsh   = mag_d << shift_k;
                        r_d.qacc  = '0;
                        r_d.neg   = neg_q;
                        r_d.lat   = stall;
                    end
                end
            end
            ST_RUN: begin
                // one restoring shift-subtract step per cycle
                if (r_q.steps != '0) begin
                    if (r_q.rem >= r_q.dsh) begin
                        r_d.rem  = r_q.rem - r_q.dsh;
                        r_d.qacc = {r_q.qacc[WIDTH-2:0], 1'b1};
                    end else begin
                        r_d.qacc = {r_q.qacc[WIDTH-2:0], 1'b0};
                    end
                    r_d.dsh   = r_q.dsh >> 1;
                    r_d.steps = r_q.steps - ONE_L;
                end
                if (r_q.cnt == '0) begin
                    r_d.done  = 1'b1;
                    r_d.quot  = r_q.neg ? (~r_q.qacc + ONE_W) : r_q.qacc;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - ONE_L;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy       = (r_q.state == ST_RUN);
    assign done       = r_q.done;
    assign quotient   = r_q.quot;
    assign lat_cycles = r_q.lat;
    assign dz_trap    = r_q.trap;
    assign trap_code  = r_q.tcode;

endmodule

// File: rtl/div_seq_unit_chk.sv
module div_seq_unit_chk #(
    parameter int WIDTH = 32,
    parameter int LAT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] divisor,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] quotient,
    input logic [LAT_W-1:0] lat_cycles,
    input logic             dz_trap
);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dz_trap |-> (!busy && !done));

    // R8
    trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> (dz_trap && !busy));

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor != '0) |=> busy);

    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lat_cycles));

    // R2
    quot_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quotient) |-> done);
endmodule

bind div_seq_unit div_seq_unit_chk #(.WIDTH(WIDTH), .LAT_W(LAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .lat_cycles(lat_cycles),
    .dz_trap   (dz_trap)
);

// File: tb/tb_div_seq_unit.sv
module tb_div_seq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LAT_W      = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              is_signed = 1'b0;
    logic [31:0]       dividend = '0;
    logic [31:0]       divisor = '0;
    logic              busy;
    logic              done;
    logic [31:0]       quotient;
    logic [LAT_W-1:0]  lat_cycles;
    logic              dz_trap;
    logic [2:0]        trap_code;

    div_seq_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .lat_cycles(lat_cycles), .dz_trap(dz_trap),
        .trap_code(trap_code)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int errors = 0;
    int checks = 0;

    // reference model state
    int          edge_no = 0;
    bit          m_busy = 0;
    int          m_due = 0;
    bit          m_done = 0;
    bit          m_trap = 0;
    logic [31:0] m_q = '0;
    logic [31:0] m_pend = '0;
    int          m_lat = 0;
    bit          m_sgn = 0;
    string       sect = "";
    logic [31:0] lfsr = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s %s actual=0x%08h expected=0x%08h",
                     req, sect, what, act, exp);
        end
    endtask

    function automatic int lz(input logic [31:0] v);
        for (int i = 31; i >= 0; i--) if (v[i]) return 31 - i;
        return 32;
    endfunction

    // expected quotient, stall count and busy length N
    task automatic calc(input bit sg, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] q, output int stl, output int n);
        bit na, nb;
        logic [31:0] ma, mb;
        int e, it;
        longint sq;
        na = sg && a[31];
        nb = sg && b[31];
        ma = na ? -a : a;
        mb = nb ? -b : b;
        e = (sg ? 6 : 5) + lz(mb) - lz(ma) + ((na != nb) ? 1 : 0);
        stl = (e >= 1) ? e - 1 : 0;  // memory time 1: threshold 2*1-1
        it = (lz(mb) >= lz(ma)) ? lz(mb) - lz(ma) + 1 : 0;
        n = (it > stl) ? it : stl;
        if (sg) begin
            sq = longint'($signed(a)) / longint'($signed(b));
            q = sq[31:0];
        end else begin
            q = a / b;
        end
    endtask

    // advance one edge: model first, then sample DUT 1 unit after the edge
    task automatic step();
        bit was_busy;
        logic [31:0] q;
        int stl, n, e;
        e = edge_no + 1;
        was_busy = m_busy;
        m_done = 0;
        m_trap = 0;
        if (was_busy && e == m_due) begin
            m_done = 1;
            m_busy = 0;
            m_q = m_pend;
        end
        if (!was_busy && start) begin
            if (divisor == 0) begin
                m_trap = 1;
            end else begin
                calc(is_signed, dividend, divisor, q, stl, n);
                m_busy = 1;
                m_due = e + n + 1;
                m_pend = q;
                m_lat = stl;
                m_sgn = is_signed;
            end
        end
        @(posedge clk);
        edge_no = e;
        #1;
        chk(done == m_done, "R7", "done", 32'(done), 32'(m_done));
        chk(busy == m_busy, "R10", "busy", 32'(busy), 32'(m_busy));
        chk(dz_trap == m_trap, "R8", "dz_trap", 32'(dz_trap), 32'(m_trap));
        chk(trap_code == (m_trap ? 3'd7 : 3'd0), "R8", "trap_code",
            32'(trap_code), m_trap ? 32'd7 : 32'd0);
        chk(quotient == m_q, m_sgn ? "R3" : "R2", "quotient", quotient, m_q);
        chk(int'(lat_cycles) == m_lat,
            (m_lat == 0) ? "R6" : (m_sgn ? "R5" : "R4"),
            "lat_cycles", 32'(lat_cycles), 32'(m_lat));
    endtask

    task automatic run_out();
        for (int k = 0; k < 60 && m_busy; k++) step();
    endtask

    task automatic go(input bit sg, input logic [31:0] a, input logic [31:0] b);
        is_signed = sg;
        dividend = a;
        divisor = b;
        start = 1'b1;
        step();
        start = 1'b0;
        run_out();
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        sect = "reset";
        // R1: all outputs zero in reset
        chk(busy == 0 && done == 0 && dz_trap == 0, "R1", "flags",
            {29'd0, busy, done, dz_trap}, 32'd0);
        chk(quotient == 0 && lat_cycles == 0 && trap_code == 0, "R1", "values",
            quotient | 32'(lat_cycles) | 32'(trap_code), 32'd0);
        rst_n = 1'b1;
        step();

        sect = "unsigned";                 // R2 R4
        go(0, 32'd100, 32'd7);
        go(0, 32'hFFFF_FFFF, 32'd1);
        go(0, 32'd0, 32'd7);               // zero dividend counts 32 zeros
        go(0, 32'd5, 32'd100);             // R6 small E
        go(0, 32'd1, 32'h4000_0000);       // R6 negative E

        sect = "signed";                   // R3 R5
        go(1, -32'sd100, 32'd7);
        go(1, 32'd100, -32'sd7);
        go(1, -32'sd100, -32'sd7);
        go(1, -32'sd7, 32'd2);
        go(1, 32'h8000_0000, 32'hFFFF_FFFF);
        go(1, 32'd0, -32'sd3);

        sect = "divzero";                  // R8
        go(0, 32'd55, 32'd0);
        step();
        go(1, -32'sd9, 32'd0);
        step();

        sect = "busy_ignore";              // R9
        is_signed = 0;
        dividend = 32'd1000;
        divisor = 32'd3;
        start = 1'b1;
        step();
        dividend = 32'd77;
        divisor = 32'd0;
        repeat (3) step();
        start = 1'b0;
        run_out();
        chk(quotient == 32'd333, "R9", "kept quotient", quotient, 32'd333);
        chk(dz_trap == 1'b0, "R9", "no trap", 32'(dz_trap), 32'd0);

        sect = "back_to_back";             // R10
        go(0, 32'd81, 32'd9);
        go(1, -32'sd81, 32'd9);

        sect = "random";
        for (int n = 0; n < 150; n++) begin
            logic [31:0] a, b;
            bit sg;
            lfsr = nxt(lfsr); a = lfsr >> lfsr[4:0];
            lfsr = nxt(lfsr); b = lfsr >> lfsr[4:0];
            lfsr = nxt(lfsr); sg = lfsr[0];
            if (lfsr[7:3] == 5'd0) b = '0;
            go(sg, a, b);
            for (int g = 0; g < int'(lfsr[9:8]) % 3; g++) step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule